// File: doc/BRIEF.md
# Priority Chip-Select Zone Decoder

This block sits between a host bus and an expansion bus with four chip-select lines. Each request carries either a 16-bit I/O address or a 28-bit memory address. The block builds the 28-bit downstream address and compares it against a fixed table of eight address zones, each defined by a base and a mask. Every chip select has a configuration word with an eight-bit zone bitmap, a fixed wait count and a variable-wait enable. The block picks the one chip select that claims the matched zone and passes on that select's timing settings. When several selects claim the same zone, the lowest index wins. When no select claims it, the result is flagged as unclaimed.

A request from a secondary management path skips zone matching. It always targets chip select 3 and uses the offset address it supplies.

Requests enter on a valid/ready handshake and results leave on one. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the outputs until `out_ready` takes it.

Top module: `csz_decoder`

## Requirements
- R1: An accepted request produces `out_valid` at the next clock edge. `out_valid` stays high until a cycle with `out_ready` high. If no new request is accepted in that cycle, it then drops.
- R2: `out_cs` has at most one bit set. `out_claimed` is 1 exactly when one bit is set, and `out_idx` is the index of that bit.
- R3: The zones are matched against the formed address, and only requests of the matching kind can hit a zone. The I/O zones are z0 `0x0060-0x006F`, z1 `0x0300-0x03FF`, z2 `0x02E0-0x02E7` and z3 `0x8000-0xFFFF`. The memory zones are z4 `0xFFF0000-0xFFFFFFF`, z5 `0xE000000-0xE0FFFFF`, z6 `0x00C0000-0x00DFFFF` and z7 `0x1000000-0x1FFFFFF`. Select n claims the request when bit k of its bitmap (`cfg_zone_map[8n+k]`) is set and zone k matches.
- R4: When several selects claim a request, the one with the lowest index is chosen.
- R5: A request that no select claims gives `out_cs`=0, `out_claimed`=0, `out_idx`=0, `out_wait_cnt`=0 and `out_var_wait`=0.
- R6: For I/O requests, `out_addr` is `in_addr[15:0]` with bits 27:16 forced to zero, whatever `in_addr[27:16]` holds.
- R7: For memory requests, `out_addr` equals `in_addr`.
- R8: `out_wait_cnt` and `out_var_wait` are the chosen select's `cfg_wait_cnt[3n+2:3n]` and `cfg_var_wait[n]`.
- R9: When `in_mgmt` is high, the result is `out_cs`=4'b1000, `out_idx`=3 and `out_claimed`=1. `out_addr` equals `in_addr`, and the timing comes from select 3. This holds even if select 3's bitmap is zero.
- R10: After reset, `out_valid`=0 and `in_ready`=1, and every result output is 0.
- R11: While `out_valid` is high and `out_ready` is low, all result outputs hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_is_io | input | 1 | 1: I/O request, 0: memory request |
| in_mgmt | input | 1 | Request from the management path |
| in_addr | input | 28 | Request address (I/O uses bits 15:0) |
| cfg_zone_map | input | 32 | Zone bitmap per select, select n at bits 8n+7:8n |
| cfg_wait_cnt | input | 12 | Fixed wait count per select, select n at bits 3n+2:3n |
| cfg_var_wait | input | 4 | Variable-wait enable per select |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle when high with out_valid |
| out_cs | output | 4 | One-hot chip select, zero when unclaimed |
| out_claimed | output | 1 | A select responds |
| out_idx | output | 2 | Index of the chosen select |
| out_addr | output | 28 | Downstream address |
| out_wait_cnt | output | 3 | Chosen select's fixed wait count |
| out_var_wait | output | 1 | Chosen select's variable-wait enable |

## Verification
The assertions check the following on every cycle:
- the shape of the result: a one-hot-or-zero select, with the claimed flag agreeing with the select bits;
- that no claiming select of lower index is passed over;
- zero upper address bits on I/O results;
- the forced select 3 for management requests;
- result hold during back-pressure.

Only the bench's scenarios can show that the zone table is matched correctly against the configured bitmaps and request kinds. The same holds for which timing values reach the output, and for a change in configuration altering the winner between requests.

// File: rtl/csz_pkg.sv
package csz_pkg;
  localparam int NUM_CS    = 4;
  localparam int NUM_ZONES = 8;
  localparam int ADDR_W    = 28;
  localparam int IO_W      = 16;
  localparam int WAIT_W    = 3;
  localparam int IDX_W     = $clog2(NUM_CS);

  // Example zone table: base/mask pairs plus the request kind each zone serves.
  localparam logic [ADDR_W-1:0] ZONE_BASE [NUM_ZONES] = '{
    28'h0000060, 28'h0000300, 28'h00002E0, 28'h0008000,
    28'hFFF0000, 28'hE000000, 28'h00C0000, 28'h1000000
  };
  localparam logic [ADDR_W-1:0] ZONE_MASK [NUM_ZONES] = '{
    28'hFFFFFF0, 28'hFFFFF00, 28'hFFFFFF8, 28'hFFF8000,
    28'hFFF0000, 28'hFF00000, 28'hFFE0000, 28'hF000000
  };
  localparam logic ZONE_IS_IO [NUM_ZONES] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0
  };

  typedef struct packed {
    logic [NUM_CS-1:0] cs;
    logic              claimed;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
    logic [WAIT_W-1:0] wait_cnt;
    logic              var_wait;
  } csz_result_t;
endpackage

// File: rtl/csz_zone_match.sv
module csz_zone_match
  import csz_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_io,
  output logic [NUM_ZONES-1:0] zone_hit
);
  for (genvar k = 0; k < NUM_ZONES; k++) begin : g_zone
    assign zone_hit[k] = (ZONE_IS_IO[k] == is_io) &&
                         ((addr & ZONE_MASK[k]) == ZONE_BASE[k]);
  end
endmodule

// File: rtl/csz_cs_arbiter.sv
module csz_cs_arbiter
  import csz_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_ZONES-1:0]        zone_hit,
  input  logic                        mgmt,
  input  logic [NUM_CS*NUM_ZONES-1:0] cfg_zone_map,
  input  logic [NUM_CS*WAIT_W-1:0]    cfg_wait_cnt,
  input  logic [NUM_CS-1:0]           cfg_var_wait,
  output logic [NUM_CS-1:0]           grant,
  output logic                        claimed,
  output logic [IDX_W-1:0]            idx,
  output logic [WAIT_W-1:0]           wait_cnt,
  output logic                        var_wait
);
  logic [NUM_CS-1:0] claim;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_claim
    assign claim[n] = |(cfg_zone_map[n*NUM_ZONES +: NUM_ZONES] & zone_hit);
  end

  always_comb begin
    grant    = '0;
    idx      = '0;
    wait_cnt = '0;
    var_wait = 1'b0;
    if (mgmt) begin
      grant[NUM_CS-1] = 1'b1;
      idx             = IDX_W'(NUM_CS-1);
    end else begin
      for (int n = NUM_CS-1; n >= 0; n--) begin
        if (claim[n]) begin
          grant    = '0;
          grant[n] = 1'b1;
          idx      = IDX_W'(n);
        end
      end
    end
    if (|grant) begin
      wait_cnt = cfg_wait_cnt[idx*WAIT_W +: WAIT_W];
      var_wait = cfg_var_wait[idx];
    end
  end

  assign claimed = mgmt || (|claim);

  // R4
  priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mgmt && grant != '0) |-> ((claim & (grant - NUM_CS'(1))) == '0));
endmodule

// File: rtl/csz_out_stage.sv
module csz_out_stage
  import csz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  csz_result_t in_res,
  output logic        out_valid,
  input  logic        out_ready,
  output csz_result_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot0(out_res.cs) && (out_res.claimed == (out_res.cs != '0))));
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/csz_decoder.sv
module csz_decoder
  import csz_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_is_io,
  input  logic                        in_mgmt,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [NUM_CS*NUM_ZONES-1:0] cfg_zone_map,
  input  logic [NUM_CS*WAIT_W-1:0]    cfg_wait_cnt,
  input  logic [NUM_CS-1:0]           cfg_var_wait,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NUM_CS-1:0]           out_cs,
  output logic                        out_claimed,
  output logic [IDX_W-1:0]            out_idx,
  output logic [ADDR_W-1:0]           out_addr,
  output logic [WAIT_W-1:0]           out_wait_cnt,
  output logic                        out_var_wait
);
  logic [ADDR_W-1:0]    formed_addr;
  logic [NUM_ZONES-1:0] zone_hit;
  csz_result_t          next_res;
  csz_result_t          held_res;

  assign formed_addr = (in_is_io && !in_mgmt) ?
                       {{(ADDR_W-IO_W){1'b0}}, in_addr[IO_W-1:0]} : in_addr;

  csz_zone_match u_match (
    .addr     (formed_addr),
    .is_io    (in_is_io),
    .zone_hit (zone_hit)
  );

  csz_cs_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .zone_hit     (zone_hit),
    .mgmt         (in_mgmt),
    .cfg_zone_map (cfg_zone_map),
    .cfg_wait_cnt (cfg_wait_cnt),
    .cfg_var_wait (cfg_var_wait),
    .grant        (next_res.cs),
    .claimed      (next_res.claimed),
    .idx          (next_res.idx),
    .wait_cnt     (next_res.wait_cnt),
    .var_wait     (next_res.var_wait)
  );

  assign next_res.addr = formed_addr;

  csz_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (next_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (held_res)
  );

  assign out_cs       = held_res.cs;
  assign out_claimed  = held_res.claimed;
  assign out_idx      = held_res.idx;
  assign out_addr     = held_res.addr;
  assign out_wait_cnt = held_res.wait_cnt;
  assign out_var_wait = held_res.var_wait;

  // R6
  io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_io && !in_mgmt) |=> (out_addr[ADDR_W-1:IO_W] == '0));
  // R9
  mgmt_cs3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mgmt) |=> (out_cs == 4'b1000 && out_claimed));
endmodule

// File: tb/csz_decoder_tb.sv
module csz_decoder_tb;
  import csz_pkg::*;

  typedef struct packed {
    logic        is_io;
    logic        mgmt;
    logic [27:0] addr;
    logic [3:0]  cs;
    logic        claimed;
    logic [27:0] eaddr;
    logic [2:0]  wcnt;
    logic        vwait;
  } vec_t;

  // cs0: z0 w1 v0 ; cs1: z0,z1,z4 w2 v1 ; cs2: z2,z4 w5 v0 ; cs3: z6 w7 v1
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 28'h0000064, 4'b0001, 1'b1, 28'h0000064, 3'd1, 1'b0}, // R4 z0 cs0 beats cs1
    '{1'b1, 1'b0, 28'h0000310, 4'b0010, 1'b1, 28'h0000310, 3'd2, 1'b1}, // R3 R8 z1
    '{1'b1, 1'b0, 28'hABC02E5, 4'b0100, 1'b1, 28'h00002E5, 3'd5, 1'b0}, // R6 z2
    '{1'b1, 1'b0, 28'h0009000, 4'b0000, 1'b0, 28'h0009000, 3'd0, 1'b0}, // R5 z3 unclaimed
    '{1'b0, 1'b0, 28'hFFF1234, 4'b0010, 1'b1, 28'hFFF1234, 3'd2, 1'b1}, // R4 R7 z4
    '{1'b0, 1'b0, 28'h00C8000, 4'b1000, 1'b1, 28'h00C8000, 3'd7, 1'b1}, // R8 z6
    '{1'b0, 1'b0, 28'hE012345, 4'b0000, 1'b0, 28'hE012345, 3'd0, 1'b0}, // R5 z5
    '{1'b0, 1'b0, 28'h0000064, 4'b0000, 1'b0, 28'h0000064, 3'd0, 1'b0}, // R3 kind mismatch
    '{1'b0, 1'b1, 28'h1234567, 4'b1000, 1'b1, 28'h1234567, 3'd7, 1'b1}, // R9
    '{1'b1, 1'b0, 28'h0000000, 4'b0000, 1'b0, 28'h0000000, 3'd0, 1'b0}  // R5 no zone
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_io = 1'b0;
  logic        in_mgmt = 1'b0;
  logic [27:0] in_addr = '0;
  logic [31:0] cfg_zone_map = {8'h40, 8'h14, 8'h13, 8'h01};
  logic [11:0] cfg_wait_cnt = {3'd7, 3'd5, 3'd2, 3'd1};
  logic [3:0]  cfg_var_wait = 4'b1010;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_cs;
  logic        out_claimed;
  logic [1:0]  out_idx;
  logic [27:0] out_addr;
  logic [2:0]  out_wait_cnt;
  logic        out_var_wait;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csz_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_io(in_is_io), .in_mgmt(in_mgmt), .in_addr(in_addr),
    .cfg_zone_map(cfg_zone_map), .cfg_wait_cnt(cfg_wait_cnt),
    .cfg_var_wait(cfg_var_wait), .out_valid(out_valid), .out_ready(out_ready),
    .out_cs(out_cs), .out_claimed(out_claimed), .out_idx(out_idx),
    .out_addr(out_addr), .out_wait_cnt(out_wait_cnt), .out_var_wait(out_var_wait)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] idx_of(input logic [3:0] cs);
    logic [1:0] r = 2'd0;
    for (int i = 0; i < 4; i++) if (cs[i]) r = 2'(i);
    return r;
  endfunction

  task automatic check_vec(input string tag, input vec_t v);
    chk({tag, " R1 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R2 cs"}, 64'(out_cs), 64'(v.cs));
    chk({tag, " R2 claimed"}, 64'(out_claimed), 64'(v.claimed));
    chk({tag, " R2 idx"}, 64'(out_idx), 64'(idx_of(v.cs)));
    chk({tag, " R6 R7 addr"}, 64'(out_addr), 64'(v.eaddr));
    chk({tag, " R8 wait"}, 64'(out_wait_cnt), 64'(v.wcnt));
    chk({tag, " R8 var"}, 64'(out_var_wait), 64'(v.vwait));
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1;
    in_is_io = v.is_io;
    in_mgmt  = v.mgmt;
    in_addr  = v.addr;
  endtask

  task automatic send(input string tag, input vec_t v);
    drive(v);
    @(posedge clk);
    #1;
    check_vec(tag, v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    vec_t a, b;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready", 64'(in_ready), 64'd1);
    chk("R10 outputs", 64'({out_cs, out_claimed, out_idx, out_addr, out_wait_cnt, out_var_wait}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) send($sformatf("vec%0d", i), VECS[i]);

    // R1: with no new request, result drains after one ready cycle
    @(posedge clk);
    #1;
    chk("R1 drain", 64'(out_valid), 64'd0);

    // R11 back-pressure hold
    a = VECS[1];
    b = VECS[4];
    @(negedge clk);
    out_ready = 1'b0;
    drive(a);
    @(posedge clk);
    #1;
    check_vec("R11 first", a);
    drive(b);
    #1;
    chk("R11 in_ready low", 64'(in_ready), 64'd0);
    @(posedge clk);
    #1;
    check_vec("R11 held", a);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    check_vec("R11 released", b);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 drop", 64'(out_valid), 64'd0);

    // R4: remove cs0 from z0, cs1 takes over
    @(negedge clk);
    cfg_zone_map[7:0] = 8'h00;
    send("R4 fallback", '{1'b1, 1'b0, 28'h0000064, 4'b0010, 1'b1, 28'h0000064, 3'd2, 1'b1});

    // R9: management path with cs3 bitmap cleared still selects cs3
    @(negedge clk);
    cfg_zone_map[31:24] = 8'h00;
    send("R9 no map", '{1'b1, 1'b1, 28'hFFF0040, 4'b1000, 1'b1, 28'hFFF0040, 3'd7, 1'b1});
    // R3: z6 now unclaimed without cs3 bitmap
    send("R3 unmapped", '{1'b0, 1'b0, 28'h00C0000, 4'b0000, 1'b0, 28'h00C0000, 3'd0, 1'b0});

    finish_run();
  end
endmodule